// File: doc/BRIEF.md
# Iterative Karatsuba Multiplier over GF(2^233)

The block computes the product of two elements of the binary field GF(2^233) in polynomial basis and returns it reduced modulo the trinomial x^233 + x^74 + 1. Each 233-bit operand is zero-extended to 236 bits and treated as four 59-bit segments. A two-level Karatsuba split turns the full product into nine 59 x 59 carry-less segment products. A single combinational schoolbook multiplier evaluates these one per clock cycle in a fixed order. Each partial product goes into a double-length accumulator at the shifts that the Karatsuba recombination assigns to it. A final cycle folds the accumulator down to 233 bits.

A caller presents both operands with a one-cycle start pulse and waits for a one-cycle done pulse. The operands are captured when start is accepted, so the inputs may change afterwards. The block handles one multiplication at a time. A start that arrives while a multiplication is in progress is dropped.

Top module: `kara_gf233_mul`

## Requirements
- R1: `result` equals the carry-less product of `op_a` and `op_b` reduced modulo x^233 + x^74 + 1, with bit i holding the coefficient of x^i.
- R2: If either operand is zero, the result is zero. Multiplying by the element 1 returns the other operand unchanged.
- R3: Exactly nine segment products are accumulated, one per cycle. `done` rises 10 rising clock edges after the edge that accepts `start`.
- R4: `done` is high for exactly one cycle per accepted start. `result` keeps its value until the next multiplication finishes.
- R5: A start seen at any edge after acceptance, up to and including the edge that produces the result, is ignored. It changes neither the result nor the number of `done` pulses.
- R6: A start given in the cycle where `done` is high is accepted, so multiplications can run back to back every 11 cycles.
- R7: While `rst_n` is low at a rising edge, `done` goes to 0 and `result` to zero.
- R8: Operand values are sampled only at the accepting edge. Later changes on `op_a`/`op_b` do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a multiplication; taken only when idle |
| op_a | input | 233 | First field operand |
| op_b | input | 233 | Second field operand |
| result | output | 233 | Reduced field product, held between runs |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
Result delivery and acceptance of a new request can meet in one cycle. A start sampled while `done` is high must be taken. A start sampled one edge earlier, in the reduction cycle, must be dropped. The bench drives both cases around the same multiplication. The scoreboard then checks three things: the ignored request adds no result, the accepted one produces its own correct product exactly 10 edges later, and the previous result stays intact until then. Every product is compared with a bit-serial shift-and-reduce reference computed in the bench.

// File: rtl/kara_pkg.sv
// Shared definitions for the iterative Karatsuba field multiplier.
// Assumes: three Karatsuba terms per level, indexed low=0, high=1, middle=2.
package kara_pkg;

    // Number of segment products in a two-level split
    localparam int NPROD = 9;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_RED  = 2'd2
    } kara_state_e;

    // Offsets (in units of the level width) that a term contributes to.
    // low term -> {0,1}, high term -> {1,2}, middle term -> {1}
    function automatic logic [2:0] term_offsets(input logic [1:0] term);
        case (term)
            2'd0:    term_offsets = 3'b011;
            2'd1:    term_offsets = 3'b110;
            default: term_offsets = 3'b010;
        endcase
    endfunction

endpackage

// File: rtl/kara_seg_mul.sv
// Classical schoolbook carry-less multiplier for one segment pair.
// Purely combinational; product width is 2*SEG_W-1.
// Assumes: operands are polynomials over GF(2), no reduction applied.
module kara_seg_mul #(
    parameter int SEG_W = 59
) (
    input  logic [SEG_W-1:0]   seg_a,
    input  logic [SEG_W-1:0]   seg_b,
    output logic [2*SEG_W-2:0] prod
);
    localparam int PP_W = 2 * SEG_W - 1;

    // Shift-and-XOR of seg_a for every set bit of seg_b
    always_comb begin
        prod = '0;
        for (int i = 0; i < SEG_W; i++) begin
            if (seg_b[i]) begin
                prod = prod ^ (PP_W'(seg_a) << i);
            end
        end
    end
endmodule

// File: rtl/kara_sel.sv
// Selects the segment operands for one step of the two-level Karatsuba
// plan. The outer term picks low half, high half or their XOR; the inner
// term does the same on the chosen half.
// Assumes: padded operands are exactly 4*SEG_W bits wide.
module kara_sel #(
    parameter int SEG_W = 59
) (
    input  logic [4*SEG_W-1:0] opa,
    input  logic [4*SEG_W-1:0] opb,
    input  logic [1:0]         outer,
    input  logic [1:0]         inner,
    output logic [SEG_W-1:0]   seg_a,
    output logic [SEG_W-1:0]   seg_b
);
    localparam int HALF_W = 2 * SEG_W;
    localparam int PAD_W  = 4 * SEG_W;

    logic [HALF_W-1:0] half_a, half_b;

    function automatic logic [HALF_W-1:0] pick_half(input logic [PAD_W-1:0] x,
                                                    input logic [1:0] t);
        case (t)
            2'd0:    pick_half = x[HALF_W-1:0];
            2'd1:    pick_half = x[PAD_W-1:HALF_W];
            default: pick_half = x[HALF_W-1:0] ^ x[PAD_W-1:HALF_W];
        endcase
    endfunction

    function automatic logic [SEG_W-1:0] pick_seg(input logic [HALF_W-1:0] x,
                                                  input logic [1:0] t);
        case (t)
            2'd0:    pick_seg = x[SEG_W-1:0];
            2'd1:    pick_seg = x[HALF_W-1:SEG_W];
            default: pick_seg = x[SEG_W-1:0] ^ x[HALF_W-1:SEG_W];
        endcase
    endfunction

    // Outer-level term selection
    always_comb begin
        half_a = pick_half(opa, outer);
        half_b = pick_half(opb, outer);
    end

    // Inner-level term selection
    always_comb begin
        seg_a = pick_seg(half_a, inner);
        seg_b = pick_seg(half_b, inner);
    end
endmodule

// File: rtl/kara_place.sv
// Places one segment product into the double-length accumulator at every
// shift the Karatsuba recombination assigns to its (outer, inner) term.
// Assumes: outer shifts are multiples of 2*SEG_W, inner of SEG_W.
module kara_place
    import kara_pkg::*;
#(
    parameter int SEG_W = 59
) (
    input  logic [2*SEG_W-2:0] prod,
    input  logic [1:0]         outer,
    input  logic [1:0]         inner,
    output logic [8*SEG_W-2:0] contrib
);
    localparam int HALF_W = 2 * SEG_W;
    localparam int ACC_W  = 8 * SEG_W - 1;

    logic [2:0] outer_m, inner_m;

    // Offset masks for the current term pair
    always_comb begin
        outer_m = term_offsets(outer);
        inner_m = term_offsets(inner);
    end

    // XOR of all shifted copies of the product
    always_comb begin
        contrib = '0;
        for (int i = 0; i < 3; i++) begin
            for (int j = 0; j < 3; j++) begin
                if (outer_m[i] && inner_m[j]) begin
                    contrib = contrib ^ (ACC_W'(prod) << (i * HALF_W + j * SEG_W));
                end
            end
        end
    end
endmodule

// File: rtl/kara_reduce.sv
// Folds the accumulated polynomial modulo x^FIELD_W + x^TAP + 1.
// Combinational; scans from the top bit down so folded bits that land
// above FIELD_W are folded again.
// Assumes: 0 < TAP < FIELD_W and ACC_W > FIELD_W.
module kara_reduce #(
    parameter int ACC_W   = 471,
    parameter int FIELD_W = 233,
    parameter int TAP     = 74
) (
    input  logic [ACC_W-1:0]   wide,
    output logic [FIELD_W-1:0] reduced
);
    logic [ACC_W-1:0] work;

    // Top-down fold of every bit at or above FIELD_W
    always_comb begin
        work = wide;
        for (int i = ACC_W - 1; i >= FIELD_W; i--) begin
            if (work[i]) begin
                work[i]                 = 1'b0;
                work[i - FIELD_W]       = ~work[i - FIELD_W];
                work[i - FIELD_W + TAP] = ~work[i - FIELD_W + TAP];
            end
        end
        reduced = work[FIELD_W-1:0];
    end
endmodule

// File: rtl/kara_gf233_mul.sv
// Iterative two-level Karatsuba multiplier over GF(2^FIELD_W).
// One segment product per cycle for nine cycles, then one reduction cycle.
// Assumes: 4*SEG_W >= FIELD_W; start is ignored unless idle.
module kara_gf233_mul
    import kara_pkg::*;
#(
    parameter int FIELD_W = 233,
    parameter int SEG_W   = 59,
    parameter int TAP     = 74
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FIELD_W-1:0] op_a,
    input  logic [FIELD_W-1:0] op_b,
    output logic [FIELD_W-1:0] result,
    output logic               done
);
    localparam int PAD_W  = 4 * SEG_W;
    localparam int PP_W   = 2 * SEG_W - 1;
    localparam int ACC_W  = 2 * PAD_W - 1;
    localparam int FILL_W = PAD_W - FIELD_W;

    kara_state_e        state;
    logic [1:0]         outer_q, inner_q;
    logic [PAD_W-1:0]   opa_q, opb_q;
    logic [ACC_W-1:0]   acc_q;
    logic [FIELD_W-1:0] result_q;
    logic               done_q;

    logic [SEG_W-1:0]   seg_a, seg_b;
    logic [PP_W-1:0]    pp;
    logic [ACC_W-1:0]   contrib;
    logic [FIELD_W-1:0] reduced;

    kara_sel #(.SEG_W(SEG_W)) u_sel (
        .opa   (opa_q),
        .opb   (opb_q),
        .outer (outer_q),
        .inner (inner_q),
        .seg_a (seg_a),
        .seg_b (seg_b)
    );

    kara_seg_mul #(.SEG_W(SEG_W)) u_segmul (
        .seg_a (seg_a),
        .seg_b (seg_b),
        .prod  (pp)
    );

    kara_place #(.SEG_W(SEG_W)) u_place (
        .prod    (pp),
        .outer   (outer_q),
        .inner   (inner_q),
        .contrib (contrib)
    );

    kara_reduce #(.ACC_W(ACC_W), .FIELD_W(FIELD_W), .TAP(TAP)) u_reduce (
        .wide    (acc_q),
        .reduced (reduced)
    );

    // Control sequence, operand capture, accumulation and result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            outer_q  <= 2'd0;
            inner_q  <= 2'd0;
            opa_q    <= '0;
            opb_q    <= '0;
            acc_q    <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        opa_q   <= {{FILL_W{1'b0}}, op_a};
                        opb_q   <= {{FILL_W{1'b0}}, op_b};
                        acc_q   <= '0;
                        outer_q <= 2'd0;
                        inner_q <= 2'd0;
                        state   <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    acc_q <= acc_q ^ contrib;
                    if (inner_q == 2'd2) begin
                        inner_q <= 2'd0;
                        if (outer_q == 2'd2) begin
                            state <= ST_RED;
                        end else begin
                            outer_q <= outer_q + 2'd1;
                        end
                    end else begin
                        inner_q <= inner_q + 2'd1;
                    end
                end
                ST_RED: begin
                    result_q <= reduced;
                    done_q   <= 1'b1;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign result = result_q;
    assign done   = done_q;

    // R2: a zero segment operand must give a zero partial product
    a_r2_zero_segment: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && seg_a == '0) |-> (pp == '0));

    // R3: the done pulse follows a run of products and one reduction cycle
    a_r3_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ($past(state, 2) == ST_RUN));

    // R4: done never lasts two cycles
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R4: result changes only at the reduction edge
    a_r4_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RED) |=> $stable(result_q));

    // R5 / R8: captured operands are frozen while busy
    a_r5_frozen_operands: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> ($stable(opa_q) && $stable(opb_q)));

    // R3: step counters stay within the three-by-three plan
    a_r3_step_range: assert property (@(posedge clk) disable iff (!rst_n)
        (outer_q != 2'd3) && (inner_q != 2'd3));
endmodule

// File: tb/kara_gf233_mul_tb.sv
module kara_gf233_mul_tb;
    localparam int FW      = 233;
    localparam int LAT     = 10;

    typedef struct {
        logic [FW-1:0] exp;
        int            edge_n;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [FW-1:0] op_a = '0;
    logic [FW-1:0] op_b = '0;
    logic [FW-1:0] result;
    logic          done;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit finished = 1'b0;
    item_t sb[$];

    kara_gf233_mul u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_a(op_a), .op_b(op_b), .result(result), .done(done)
    );

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    // Bit-serial reference: Horner over op_b, reduce by x^233 = x^74 + 1
    function automatic logic [FW-1:0] ref_mul(input logic [FW-1:0] a, input logic [FW-1:0] b);
        logic [FW-1:0] r = '0;
        logic top;
        for (int i = FW - 1; i >= 0; i--) begin
            top = r[FW-1];
            r = {r[FW-2:0], 1'b0};
            if (top) begin
                r[0]  = ~r[0];
                r[74] = ~r[74];
            end
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    function automatic logic [FW-1:0] rnd();
        logic [255:0] w;
        for (int k = 0; k < 8; k++) w[k*32 +: 32] = $urandom;
        return w[FW-1:0];
    endfunction

    task automatic check(input bit ok, input string tag, input logic [FW-1:0] act,
                         input logic [FW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: issue one request at the next edge and push its expectation
    task automatic issue(input logic [FW-1:0] a, input logic [FW-1:0] b, input string tag);
        item_t it;
        start = 1'b1; op_a = a; op_b = b;
        it.exp = ref_mul(a, b);
        it.edge_n = cyc + 1 + LAT;
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        start = 1'b0; op_a = rnd(); op_b = rnd();   // R8: inputs scrambled after capture
    endtask

    task automatic wait_until(input int e);
        while (cyc < e) @(negedge clk);
    endtask

    task automatic run_one(input logic [FW-1:0] a, input logic [FW-1:0] b, input string tag);
        int s;
        s = cyc + 1;
        issue(a, b, tag);
        wait_until(s + LAT + 1);
    endtask

    // Monitor: pop and compare on every done pulse, check result hold
    logic [FW-1:0] last_res = '0;
    bit            hold_chk = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (hold_chk) begin
                check(!done && result == last_res, "R4 pulse/hold", result, last_res);
                hold_chk = 1'b0;
            end
            if (done) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R5 extra done", result, '0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(result == it.exp, it.tag, result, it.exp);
                    check(cyc == it.edge_n, "R3 latency", FW'(cyc), FW'(it.edge_n));
                end
                last_res = result;
                hold_chk = 1'b1;
            end
        end
    end

    initial begin
        logic [FW-1:0] x, y, one, allones;
        int s;
        one = '0; one[0] = 1'b1;
        allones = '1;
        repeat (3) @(negedge clk);
        // R7: reset state
        check(done == 1'b0, "R7 done in reset", FW'(done), '0);
        check(result == '0, "R7 result in reset", result, '0);
        rst_n = 1'b1;
        @(negedge clk);

        x = rnd();
        run_one('0, x, "R2 zero*rand");
        run_one(x, '0, "R2 rand*zero");
        run_one(one, x, "R2 one*rand");
        run_one(allones, allones, "R1 ones*ones");
        y = '0; y[FW-1] = 1'b1;
        run_one(y, y, "R1 top*top reduce");
        for (int k = 0; k < 10; k++) run_one(rnd(), rnd(), "R1 random");

        // R5: starts during run and in the reduction cycle; R6: start while done high
        x = rnd(); y = rnd();
        s = cyc + 1;
        issue(x, y, "R5 busy run");
        wait_until(s + 3);
        start = 1'b1; op_a = rnd(); op_b = rnd();
        @(negedge clk); start = 1'b0;
        wait_until(s + LAT - 1);           // next edge is the reduction edge
        start = 1'b1; op_a = rnd(); op_b = rnd();
        @(negedge clk); start = 1'b0;      // now cyc == s+LAT, done high
        check(done == 1'b1, "R6 done before back-to-back", FW'(done), FW'(1));
        x = rnd(); y = rnd();
        s = cyc + 1;
        issue(x, y, "R6 back-to-back");
        wait_until(s + LAT + 15);          // any extra done would be flagged

        check(sb.size() == 0, "R3 all results seen", FW'(sb.size()), '0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule